// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit gathers single-cycle event pulses from the command and data engines of a card host controller. It keeps them in a sticky raw status register until software clears them by writing ones. A mask register picks which pending events reach the masked status view and the interrupt line. A control bit enables that line as a whole. A separate output reports, whatever the mask, whether any error-class event is pending.

Three bit positions have two sources. In normal operation bits 8, 9 and 10 record response timeout, data timeout and data starvation. While the alternate-event mode input is high, the same three bits record boot-acknowledge received, boot start and voltage-switch done. These alternate events come in on a dedicated three-bit input. The register block is a simple single-port map. Writes take effect on the clock edge. Read data depends only on the current address and is not registered.

Top module: `cc_irq_status`

## Requirements
- R1: After a synchronous active-low reset, the raw status, mask and interrupt-enable registers are all zero, and `irq_o` and `err_sum_o` are low.
- R2: A pulse on `evt_i[k]` at a defined position (bits 1 to 16, 30, 31) sets raw bit k on that clock edge. The bit stays set until it is cleared. Raw status is read at offset 0x38.
- R3: A write to offset 0x38 clears each raw bit whose write-data bit is 1 and leaves every other raw bit as it was. Writing 0xFFFFFFFF clears every pending event.
- R4: When an event pulse and a clearing write hit the same bit on the same edge, the bit ends up set.
- R5: The mask register is written and read at offset 0x30. The masked status, read at 0x34, equals raw AND mask. Writes to 0x34 have no effect.
- R6: `irq_o` is high exactly when the enable bit is set and the masked status is nonzero. The enable bit is bit 4 of the control register at offset 0x00. The other control bits read 0.
- R7: `err_sum_o` is the OR of raw bits 1, 6, 7, 8, 11, 12, 13 and 15, independent of the mask.
- R8: With `alt_mode_i` high, raw bits 8, 9 and 10 are set by `alt_evt_i[0]`, `alt_evt_i[1]` and `alt_evt_i[2]`, and `evt_i[10:8]` are ignored. With `alt_mode_i` low, `alt_evt_i` is ignored.
- R9: Undefined positions (bit 0 and bits 17 to 29) never become set in raw status or in the mask, and they read 0.
- R10: Reads of any offset other than 0x00, 0x30, 0x34 and 0x38 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 32 | Event pulses at normal bit positions |
| alt_evt_i | input | 3 | Boot-ack, boot-start and voltage-switch-done pulses |
| alt_mode_i | input | 1 | Routes alt_evt_i onto bits 8 to 10 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| err_sum_o | output | 1 | Any error-class event pending |

## Verification
The assertions assume that event inputs are sampled only on clock edges, with no meaning given to pulse width. They also assume that `alt_mode_i` is steady around any edge that carries an event. The bench drives every input on the falling edge, so each event is a one-cycle pulse seen by exactly one rising edge. It changes the mode only when no event is active. Every clearing write is a single-cycle strobe, so each cleared bit is attributed to one edge.

// File: rtl/cc_irq_pkg.sv
// Shared constants and types for the card host interrupt status unit.
// Assumes a 32-bit register file with byte offsets in an 8-bit space.
package cc_irq_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h38;

    localparam int unsigned CTRL_IEN_BIT = 4;

    // defined event positions: 1..16, 30, 31
    localparam logic [REG_W-1:0] IMPL_BITS = 32'hC001_FFFE;
    // error class positions: 1,6,7,8,11,12,13,15
    localparam logic [REG_W-1:0] ERR_BITS  = 32'h0000_B9C2;

    // dual-meaning window: alternate events land here
    localparam int unsigned ALT_LSB = 8;
    localparam int unsigned ALT_N   = 3;

    typedef struct packed {
        logic ctrl;
        logic mask;
        logic mstat;
        logic raw;
    } reg_sel_t;
endpackage

// File: rtl/cc_irq_decode.sv
// Address decoder: turns the byte offset into one-hot register selects.
// Assumes offsets are compared in full; no aliasing.
module cc_irq_decode
    import cc_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    // one-hot select of the addressed register
    always_comb begin
        sel_o       = '0;
        sel_o.ctrl  = (addr_i == OFS_CTRL);
        sel_o.mask  = (addr_i == OFS_MASK);
        sel_o.mstat = (addr_i == OFS_MSTAT);
        sel_o.raw   = (addr_i == OFS_RAW);
    end
endmodule

// File: rtl/cc_irq_raw.sv
// Sticky raw event status with write-one-to-clear.
// Routes alternate events onto the dual-meaning window when alt_mode_i is set.
// An event on the same edge as a clear of that bit wins.
// Assumes events are one-cycle pulses sampled on the rising edge.
module cc_irq_raw
    import cc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic [ALT_N-1:0] alt_evt_i,
    input  logic             alt_mode_i,
    input  logic             clr_we_i,
    input  logic [REG_W-1:0] clr_data_i,
    output logic [REG_W-1:0] raw_o
);
    logic [REG_W-1:0] evt_eff;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] raw_q;

    // per-bit source selection; undefined positions tied off
    for (genvar k = 0; k < REG_W; k++) begin : g_src
        if (!IMPL_BITS[k]) begin : g_none
            assign evt_eff[k] = 1'b0;
        end else if (k >= ALT_LSB && k < ALT_LSB + ALT_N) begin : g_dual
            assign evt_eff[k] = alt_mode_i ? alt_evt_i[k-ALT_LSB] : evt_i[k];
        end else begin : g_plain
            assign evt_eff[k] = evt_i[k];
        end
    end

    assign clr_vec = clr_we_i ? clr_data_i : '0;

    // capture events, clear on write, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (evt_eff | (raw_q & ~clr_vec)) & IMPL_BITS;
    end

    assign raw_o = raw_q;

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_eff != '0) |=> ((raw_q & $past(evt_eff)) == $past(evt_eff)));

    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~evt_eff) != '0) |=> ((raw_q & $past(clr_vec & ~evt_eff)) == '0));

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(raw_q & ~clr_vec)) == $past(raw_q & ~clr_vec)));

    // R9
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q & ~IMPL_BITS) == '0);
endmodule

// File: rtl/cc_irq_out.sv
// Mask and enable registers plus the masked status, interrupt and error summary.
// Assumes raw_i comes straight from the status register (no glitch filtering).
module cc_irq_out
    import cc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] raw_i,
    input  logic             mask_we_i,
    input  logic             ctrl_we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] mask_o,
    output logic             ien_o,
    output logic [REG_W-1:0] mstat_o,
    output logic             irq_o,
    output logic             err_o
);
    logic [REG_W-1:0] mask_q;
    logic             ien_q;

    // mask register keeps defined positions only
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= wdata_i & IMPL_BITS;
    end

    // global interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)         ien_q <= 1'b0;
        else if (ctrl_we_i) ien_q <= wdata_i[CTRL_IEN_BIT];
    end

    // derived views of the pending events
    always_comb begin
        mstat_o = raw_i & mask_q;
        irq_o   = ien_q && (mstat_o != '0);
        err_o   = |(raw_i & ERR_BITS);
    end

    assign mask_o = mask_q;
    assign ien_o  = ien_q;

    // R6
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && !wdata_i[CTRL_IEN_BIT]) |=> !irq_o);

    // R5
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && wdata_i == '0) |=> (mstat_o == '0 && !irq_o));

    // R9
    mask_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~IMPL_BITS) == '0);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == '0) |-> !err_o);
endmodule

// File: rtl/cc_irq_status.sv
// Top of the card host interrupt status unit.
// Wires decode, raw status and output logic; read data is combinational on addr_i.
// Assumes a single writer; a write and a read share addr_i.
module cc_irq_status
    import cc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      evt_i,
    input  logic [2:0]       alt_evt_i,
    input  logic             alt_mode_i,
    input  logic             wr_en_i,
    input  logic [7:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic             irq_o,
    output logic             err_sum_o
);
    reg_sel_t         sel;
    logic [REG_W-1:0] raw;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] mstat;
    logic             ien;

    cc_irq_decode u_dec (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    cc_irq_raw u_raw (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .alt_evt_i  (alt_evt_i),
        .alt_mode_i (alt_mode_i),
        .clr_we_i   (wr_en_i && sel.raw),
        .clr_data_i (wdata_i),
        .raw_o      (raw)
    );

    cc_irq_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_i     (raw),
        .mask_we_i (wr_en_i && sel.mask),
        .ctrl_we_i (wr_en_i && sel.ctrl),
        .wdata_i   (wdata_i),
        .mask_o    (mask),
        .ien_o     (ien),
        .mstat_o   (mstat),
        .irq_o     (irq_o),
        .err_o     (err_sum_o)
    );

    // read-back multiplexer; unmapped offsets return zero
    always_comb begin
        rdata_o = '0;
        if (sel.ctrl)  rdata_o[CTRL_IEN_BIT] = ien;
        if (sel.mask)  rdata_o = mask;
        if (sel.mstat) rdata_o = mstat;
        if (sel.raw)   rdata_o = raw;
    end
endmodule

// File: tb/cc_irq_status_tb.sv
module cc_irq_status_tb_top;
    localparam logic [31:0] IMPL = 32'hC001_FFFE;
    localparam logic [31:0] ERRM = 32'h0000_B9C2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic [2:0]  alt_evt_i = '0;
    logic        alt_mode_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o, err_sum_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cc_irq_status dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] e, input logic [2:0] ae);
        @(negedge clk);
        evt_i = e; alt_evt_i = ae;
        @(negedge clk);
        evt_i = '0; alt_evt_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    initial begin
        logic [31:0] d, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h38, d); chk("R1 raw", d, 0);
        rd(8'h30, d); chk("R1 mask", d, 0);
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
        chk("R1 err", {31'b0, err_sum_o}, 0);

        // R2 R7 R9 R3: sweep each position, normal mode
        for (int k = 0; k < 32; k++) begin
            e = (32'h1 << k) & IMPL;
            pulse(32'h1 << k, 3'b0);
            rd(8'h38, d); chk("R2/R9 raw set", d, e);
            chk("R7 err", {31'b0, err_sum_o}, {31'b0, |(e & ERRM)});
            pulse(0, 3'b0);
            rd(8'h38, d); chk("R2 sticky", d, e);
            wr(8'h38, 32'h1 << k);
            rd(8'h38, d); chk("R3 clear one", d, 0);
        end

        // R8 normal mode ignores alt inputs
        pulse(0, 3'b111);
        rd(8'h38, d); chk("R8 alt ignored", d, 0);

        // R8 alt mode sweep
        @(negedge clk); alt_mode_i = 1'b1;
        for (int k = 0; k < 32; k++) begin
            e = (k >= 8 && k <= 10) ? 32'h0 : ((32'h1 << k) & IMPL);
            pulse(32'h1 << k, 3'b0);
            rd(8'h38, d); chk("R8 alt mode evt", d, e);
            wr(8'h38, 32'hFFFF_FFFF);
        end
        for (int j = 0; j < 3; j++) begin
            pulse(0, 3'(1 << j));
            rd(8'h38, d); chk("R8 alt evt", d, 32'h100 << j);
            chk("R7 err alt", {31'b0, err_sum_o}, {31'b0, j == 0});
            wr(8'h38, 32'hFFFF_FFFF);
        end
        @(negedge clk); alt_mode_i = 1'b0;

        // R3 partial clear and full clear
        pulse(32'hFFFF_FFFF, 3'b0);
        rd(8'h38, d); chk("R2 all set", d, IMPL);
        wr(8'h38, 32'h0000_00F0);
        rd(8'h38, d); chk("R3 partial", d, IMPL & ~32'hF0);
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, d); chk("R3 all ones", d, 0);

        // R4 collision
        @(negedge clk);
        evt_i = 32'h4; wr_en_i = 1'b1; addr_i = 8'h38; wdata_i = 32'hFFFF_FFFF;
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0;
        rd(8'h38, d); chk("R4 event wins", d, 32'h4);
        wr(8'h38, 32'hFFFF_FFFF);

        // R5 R6 R9 mask sweep
        pulse(32'hFFFF_FFFF, 3'b0);
        wr(8'h00, 32'h10);
        rd(8'h00, d); chk("R6 ctrl read", d, 32'h10);
        for (int k = 0; k < 32; k++) begin
            e = (32'h1 << k) & IMPL;
            wr(8'h30, 32'h1 << k);
            rd(8'h30, d); chk("R9 mask read", d, e);
            rd(8'h34, d); chk("R5 masked", d, e);
            chk("R6 irq", {31'b0, irq_o}, {31'b0, e != 0});
        end
        wr(8'h34, 32'h0);
        rd(8'h34, d); chk("R5 mstat write ignored", d, 32'h8000_0000);
        wr(8'h00, 32'hFFFF_FFEF);
        chk("R6 irq disabled", {31'b0, irq_o}, 0);
        rd(8'h00, d); chk("R6 ctrl others zero", d, 0);
        wr(8'h30, 32'h0000_0002);
        wr(8'h38, 32'h0000_0002);
        rd(8'h34, d); chk("R5 masked after clear", d, 0);

        // R10 unmapped
        rd(8'h3C, d); chk("R10 unmapped", d, 0);
        rd(8'h04, d); chk("R10 unmapped", d, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule